// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block watches two digitized voltages, the main supply code and the backup-cell code, and derives three supervisory actions from them. Every switch point is a fixed ratio of the backup-cell code, so the thresholds follow the cell that is actually fitted rather than fixed levels. Below 1.45 times the cell voltage an early-warning interrupt is requested, if software enabled it, while the processor keeps running. Below 1.40 times the cell voltage the processor is held in reset and the memory enables and write strobe are forced inactive. Below the cell voltage itself the storage supply is switched over to the cell.

When the supply recovers above the reset threshold, the memory inhibit is lifted at once but the processor reset is held for a fixed number of clocks (21,504 by default) before release. A dip below the reset threshold during that wait starts it again from the beginning. The same wait applies after the block's own reset, which acts as a power-on event.

The ratios are evaluated in exact fixed-point arithmetic: the supply code, shifted left by 8 bits, is compared with the cell code times 371 (warning) or 358 (reset). The converters and analog comparators sit outside this block.

Top module: `pfs_supervisor`

## Requirements
- R1: The supply is below the warning threshold when supply_code*256 < cell_code*371.
- R2: When supply_code*256 < cell_code*358, cpu_rst is 1 and mem_inhibit is 1.
- R3: batt_sel is 1 exactly when supply_code < cell_code.
- R4: A warning interrupt is raised only if warn_en is 1 when the falling crossing is sampled; warn_vec reads 16'h002B in the cycle warn_irq is 1 and 0 in every other cycle. A crossing sampled with warn_en at 0 is consumed: setting warn_en later while still below gives no interrupt.
- R5: mem_inhibit is 1 only while the supply is below the reset threshold; it is 0 during the release wait although cpu_rst is still 1.
- R6: After the supply code is applied at or above the reset threshold, cpu_rst falls at the HOLD_CYCLES+2nd rising edge; the same count runs from the release of rst_n.
- R7: A dip below the reset threshold during the release wait restarts the wait from zero; cpu_rst stays 1 throughout.
- R8: warn_irq is a one-cycle pulse, raised once per falling crossing of the warning threshold, and re-armed only after the supply has been sampled at or above that threshold.
- R9: No warning interrupt is raised when the crossing is sampled with the supply already below the reset threshold.
- R10: While rst_n is 0: cpu_rst = 1, mem_inhibit = 1, warn_irq = 0, warn_vec = 0, batt_sel = 0.
- R11: A change of the input codes reaches batt_sel, mem_inhibit and warn_irq at the second rising edge after it is applied, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-on |
| supply_code | input | VW | Digitized main supply voltage, unsigned |
| cell_code | input | VW | Digitized backup-cell voltage, unsigned |
| warn_en | input | 1 | Enables the early-warning interrupt |
| warn_irq | output | 1 | One-cycle early-warning interrupt request |
| warn_vec | output | 16 | Interrupt vector, valid with warn_irq |
| cpu_rst | output | 1 | Processor reset, active high |
| mem_inhibit | output | 1 | Forces memory enables and write strobe inactive |
| batt_sel | output | 1 | Selects the backup cell as storage supply |

## Verification
Every output has a two-edge path: the comparison flags register at the first rising edge after an input change and the outputs at the second, so the bench drives on a falling edge and samples after two more falling edges, which also lets it confirm that nothing has moved after only one. The release of cpu_rst is due HOLD_CYCLES+2 rising edges after a healthy supply is applied (or after rst_n rises); the bench counts edges one by one to the fall and compares the count exactly. The warning pulse is due two edges after the crossing, and the bench counts pulses over a window several cycles long, so a missing, repeated or late pulse is seen as a wrong count.

// File: rtl/pfs_pkg.sv
// Shared types of the power-fail supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package pfs_pkg;

    // Sequencer states: supply low, waiting out the release delay, running.
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } pfs_state_t;

    // Registered comparison results plus the enable sampled alongside them.
    typedef struct packed {
        logic below_warn;
        logic below_rst;
        logic below_cell;
        logic warn_en;
    } pfs_flags_t;

endpackage

// File: rtl/pfs_threshold.sv
// Ratio comparators: compares the supply code with scaled multiples of the
// cell code in exact fixed point and registers the results.
// Assumes: ratios are given as integers with FRAC fractional bits and are
// below 2.0; the cell-ratio (1.0) comparison needs no multiply.
module pfs_threshold
    import pfs_pkg::*;
#(
    parameter int unsigned VW     = 8,
    parameter int unsigned FRAC   = 8,
    parameter int unsigned WARN_K = 371,
    parameter int unsigned RST_K  = 358
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] supply_code,
    input  logic [VW-1:0] cell_code,
    input  logic          warn_en,
    output pfs_flags_t    flags_q
);
    localparam int unsigned PW = VW + FRAC + 2;
    localparam int unsigned NR = 2;
    localparam int unsigned RATIO_K [NR] = '{WARN_K, RST_K};

    logic [PW-1:0] supply_scaled;
    logic [NR-1:0] below;

    assign supply_scaled = PW'(supply_code) << FRAC;

    // One comparator per ratio: index 0 warning, index 1 reset.
    for (genvar i = 0; i < NR; i++) begin : g_ratio
        assign below[i] = supply_scaled < (PW'(cell_code) * PW'(RATIO_K[i]));
    end

    // Register the flags; reset treats the supply as below the warning and reset points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{below_warn: 1'b1, below_rst: 1'b1, below_cell: 1'b0, warn_en: 1'b0};
        end else begin
            flags_q.below_warn <= below[0];
            flags_q.below_rst  <= below[1];
            flags_q.below_cell <= supply_code < cell_code;
            flags_q.warn_en    <= warn_en;
        end
    end

endmodule

// File: rtl/pfs_sequencer.sv
// Reset sequencer: holds the processor in reset and inhibits memory while the
// supply is below the reset point, then waits HOLD_CYCLES clocks before
// releasing reset. Also registers the battery-select output.
// Assumes: HOLD_CYCLES >= 1; inputs are registered flags.
module pfs_sequencer
    import pfs_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 21504
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_rst,
    input  logic below_cell,
    output logic cpu_rst,
    output logic mem_inhibit,
    output logic batt_sel
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    pfs_state_t    state;
    logic [CW-1:0] cnt;

    // State, delay counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_DOWN;
            cnt         <= '0;
            cpu_rst     <= 1'b1;
            mem_inhibit <= 1'b1;
            batt_sel    <= 1'b0;
        end else begin
            batt_sel <= below_cell;
            if (below_rst) begin
                state       <= ST_DOWN;
                cnt         <= '0;
                cpu_rst     <= 1'b1;
                mem_inhibit <= 1'b1;
            end else begin
                case (state)
                    ST_DOWN: begin
                        state       <= ST_WAIT;
                        cnt         <= '0;
                        cpu_rst     <= 1'b1;
                        mem_inhibit <= 1'b0;
                    end
                    ST_WAIT: begin
                        mem_inhibit <= 1'b0;
                        if (cnt == CW'(HOLD_CYCLES - 1)) begin
                            state   <= ST_RUN;
                            cpu_rst <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        state       <= ST_RUN;
                        cpu_rst     <= 1'b0;
                        mem_inhibit <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pfs_warn.sv
// Early-warning interrupt: raises a one-cycle request with its vector on the
// first cycle the supply is seen below the warning point, then stays quiet
// until the supply has been seen above that point again.
// Assumes: inputs are registered flags.
module pfs_warn
    import pfs_pkg::*;
#(
    parameter logic [15:0] IRQ_VECTOR = 16'h002B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pfs_flags_t  flags,
    output logic        warn_irq,
    output logic [15:0] warn_vec
);
    logic armed;

    // Arm above the warning point; consume the crossing and pulse if allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            warn_irq <= 1'b0;
            warn_vec <= '0;
        end else begin
            warn_irq <= 1'b0;
            warn_vec <= '0;
            if (!flags.below_warn) begin
                armed <= 1'b1;
            end else if (armed) begin
                armed <= 1'b0;
                if (flags.warn_en && !flags.below_rst) begin
                    warn_irq <= 1'b1;
                    warn_vec <= IRQ_VECTOR;
                end
            end
        end
    end

endmodule

// File: rtl/pfs_supervisor.sv
// Power-fail supervisor top: ratio comparators feeding a reset sequencer and
// an early-warning interrupt generator. All outputs are registered two clock
// edges after the inputs.
// Assumes: supply_code and cell_code are synchronous to clk.
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned VW          = 8,
    parameter int unsigned FRAC        = 8,
    parameter int unsigned WARN_K      = 371,
    parameter int unsigned RST_K       = 358,
    parameter int unsigned HOLD_CYCLES = 21504,
    parameter logic [15:0] IRQ_VECTOR  = 16'h002B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] supply_code,
    input  logic [VW-1:0] cell_code,
    input  logic          warn_en,
    output logic          warn_irq,
    output logic [15:0]   warn_vec,
    output logic          cpu_rst,
    output logic          mem_inhibit,
    output logic          batt_sel
);
    pfs_flags_t flags_q;

    pfs_threshold #(
        .VW(VW), .FRAC(FRAC), .WARN_K(WARN_K), .RST_K(RST_K)
    ) u_thr (
        .clk(clk), .rst_n(rst_n),
        .supply_code(supply_code), .cell_code(cell_code),
        .warn_en(warn_en), .flags_q(flags_q)
    );

    pfs_sequencer #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .below_rst(flags_q.below_rst), .below_cell(flags_q.below_cell),
        .cpu_rst(cpu_rst), .mem_inhibit(mem_inhibit), .batt_sel(batt_sel)
    );

    pfs_warn #(.IRQ_VECTOR(IRQ_VECTOR)) u_warn (
        .clk(clk), .rst_n(rst_n), .flags(flags_q),
        .warn_irq(warn_irq), .warn_vec(warn_vec)
    );

endmodule

// File: rtl/pfs_supervisor_chk.sv
// Property checker for pfs_supervisor, attached by bind below.
// Assumes: observes top-level ports only.
module pfs_supervisor_chk #(
    parameter int unsigned HOLD_CYCLES = 21504,
    parameter logic [15:0] IRQ_VECTOR  = 16'h002B
) (
    input logic        clk,
    input logic        rst_n,
    input logic        warn_irq,
    input logic [15:0] warn_vec,
    input logic        cpu_rst,
    input logic        mem_inhibit,
    input logic        batt_sel
);
    logic [31:0] run_len;

    // Length of the current stretch of reset held with memory enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                     run_len <= '0;
        else if (cpu_rst && !mem_inhibit) run_len <= run_len + 1;
        else                            run_len <= '0;
    end

    p_inhibit_holds_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> cpu_rst);
    p_vec_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> warn_vec == IRQ_VECTOR);
    p_vec_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !warn_irq |-> warn_vec == 16'h0000);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);
    p_no_irq_when_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> !mem_inhibit);
    p_batt_implies_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> mem_inhibit);
    p_hold_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> run_len == HOLD_CYCLES);

endmodule

bind pfs_supervisor pfs_supervisor_chk #(
    .HOLD_CYCLES(HOLD_CYCLES), .IRQ_VECTOR(IRQ_VECTOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .warn_irq(warn_irq), .warn_vec(warn_vec),
    .cpu_rst(cpu_rst), .mem_inhibit(mem_inhibit), .batt_sel(batt_sel)
);

// File: tb/sim_pfs_supervisor.sv
`timescale 1ns/1ps
module sim_pfs_supervisor;
    localparam int VW   = 6;
    localparam int HOLD = 20;
    localparam int MAXC = (1 << VW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VW-1:0] supply_code = '0;
    logic [VW-1:0] cell_code = '0;
    logic warn_en = 1'b0;
    logic warn_irq, cpu_rst, mem_inhibit, batt_sel;
    logic [15:0] warn_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfs_supervisor #(.VW(VW), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .cell_code(cell_code),
        .warn_en(warn_en), .warn_irq(warn_irq), .warn_vec(warn_vec),
        .cpu_rst(cpu_rst), .mem_inhibit(mem_inhibit), .batt_sel(batt_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input int s, input int c);
        supply_code = VW'(s);
        cell_code   = VW'(c);
    endtask

    // Count warning pulses over n cycles; checks the vector on each (R4).
    task automatic count_irq(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (warn_irq) begin
                cnt++;
                chk(warn_vec == 16'h002B, "R4 vector", int'(warn_vec), 16'h002B);
            end
        end
    endtask

    // Count edges until cpu_rst falls (R6).
    task automatic edges_to_release(output int e);
        e = 0;
        for (int k = 1; k <= 4 * HOLD; k++) begin
            @(negedge clk);
            if (!cpu_rst) begin e = k; break; end
        end
    endtask

    function automatic bit f_warn(input int s, input int c); return s * 256 < c * 371; endfunction
    function automatic bit f_rst (input int s, input int c); return s * 256 < c * 358; endfunction

    initial begin
        int e, n;
        drive(63, 40);
        step(3);
        // R10: state while rst_n is low
        chk(cpu_rst == 1'b1, "R10 cpu_rst", int'(cpu_rst), 1);
        chk(mem_inhibit == 1'b1, "R10 mem_inhibit", int'(mem_inhibit), 1);
        chk(warn_irq == 1'b0 && warn_vec == 16'h0, "R10 irq", int'(warn_irq), 0);
        chk(batt_sel == 1'b0, "R10 batt_sel", int'(batt_sel), 0);

        // R6: power-on release count
        rst_n = 1'b1;
        edges_to_release(e);
        chk(e == HOLD + 2, "R6 power-on release edges", e, HOLD + 2);

        // R11: one edge later nothing has moved, two edges later it has
        drive(20, 40);
        step(1);
        chk(mem_inhibit == 1'b0, "R11 first edge", int'(mem_inhibit), 0);
        step(1);
        chk(mem_inhibit == 1'b1, "R11 second edge", int'(mem_inhibit), 1);

        // R1 R2 R3 R5: exhaustive sweep of both codes
        for (int c = 0; c <= MAXC; c++) begin
            for (int s = 0; s <= MAXC; s++) begin
                drive(s, c);
                step(2);
                chk(batt_sel == (s < c), "R3 batt_sel", int'(batt_sel), int'(s < c));
                chk(mem_inhibit == f_rst(s, c), "R5 mem_inhibit", int'(mem_inhibit), int'(f_rst(s, c)));
                if (f_rst(s, c))
                    chk(cpu_rst == 1'b1, "R2 cpu_rst", int'(cpu_rst), 1);
            end
        end

        // R1 R4 R9: warning sweep from an armed state, enable varied
        for (int c = 0; c <= 43; c++) begin
            for (int s = 0; s <= MAXC; s++) begin
                int exp_n;
                warn_en = 1'b1;
                drive(MAXC, c);
                step(3);
                warn_en = s[0];
                drive(s, c);
                exp_n = (f_warn(s, c) && !f_rst(s, c) && s[0]) ? 1 : 0;
                count_irq(4, n);
                chk(n == exp_n, "R1 warning pulse count", n, exp_n);
            end
        end

        // Settle into running with cell 40 (warning 58, reset 56)
        warn_en = 1'b1;
        drive(63, 40);
        step(HOLD + 6);
        chk(cpu_rst == 1'b0, "R6 running", int'(cpu_rst), 0);

        // R8: one pulse per crossing, re-armed after recovery
        drive(57, 40);
        count_irq(12, n);
        chk(n == 1, "R8 single pulse per crossing", n, 1);
        drive(63, 40); step(3);
        drive(57, 40);
        count_irq(6, n);
        chk(n == 1, "R8 re-armed crossing", n, 1);

        // R4: crossing with enable low is consumed
        drive(63, 40); step(3);
        warn_en = 1'b0;
        drive(57, 40);
        count_irq(4, n);
        chk(n == 0, "R4 disabled crossing", n, 0);
        warn_en = 1'b1;
        count_irq(6, n);
        chk(n == 0, "R4 late enable", n, 0);

        // R9: direct drop below the reset point gives no pulse
        drive(63, 40); step(3);
        drive(50, 40);
        count_irq(6, n);
        chk(n == 0, "R9 drop to reset", n, 0);

        // R6 R5: plain recovery
        drive(63, 40);
        step(2);
        chk(mem_inhibit == 1'b0 && cpu_rst == 1'b1, "R5 wait phase", int'(mem_inhibit), 0);
        step(HOLD + 2);
        chk(cpu_rst == 1'b0, "R6 recovered", int'(cpu_rst), 0);

        // R7: dip during the wait restarts the count
        drive(20, 40); step(4);
        drive(63, 40); step(HOLD / 2);
        chk(cpu_rst == 1'b1, "R7 mid wait", int'(cpu_rst), 1);
        drive(20, 40); step(3);
        chk(cpu_rst == 1'b1, "R7 during dip", int'(cpu_rst), 1);
        drive(63, 40);
        edges_to_release(e);
        chk(e == HOLD + 2, "R7 restarted release edges", e, HOLD + 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule